// File: doc/BRIEF.md
# Hash Job Register and Nonce Scanner

This block takes a mining-style hashing job from a host running on a slow register clock and sweeps a window of 32-bit nonces in a processing domain that runs twice as fast. The host writes the job one word per cycle with a 4-bit address, a 32-bit data word and a single-cycle valid strobe. A job is made of a precomputed eight-word hash state, three trailing message words, the first and last nonce of an inclusive window, and a command word. Writing the start command hands the job across the clock boundary.

Once a job is accepted, the scanner issues one candidate nonce per processing cycle to an external hash pipeline of fixed depth. It also drives the captured hash state and trailing words toward that pipeline. The pipeline returns a valid strobe together with the nonce that travelled with the result and a 256-bit digest. A digest whose most significant word is zero is reported as found, and the nonce and digest are latched. After the last candidate has drained out of the pipeline, a reached-end pulse is raised. A new start command while a scan runs restarts the sweep from the new window.

Top module: `hash_job_scanner`

## Requirements
- R1: While reset (asynchronous, active high) is asserted, cand_valid, found_pulse and end_pulse are low and found_nonce, found_digest, job_state and job_tail are all zero.
- R2: A host write to address a in 0..7 sets hash-state word a, presented on job_state bits 32a+31 down to 32a; addresses 8, 9 and 10 set trailing words 0, 1 and 2 on job_tail bits 32(a-8)+31 down to 32(a-8). Both outputs take the written values when a start is accepted and hold them until the next start. Writes to addresses 14 and 15 change nothing.
- R3: After a start, cand_valid is high for exactly one processing cycle per nonce, with cand_nonce stepping by one per cycle from the first nonce (address 11) to the last nonce (address 12) inclusive, including a window that ends at 0xFFFFFFFF.
- R4: end_pulse is a single-cycle pulse raised exactly PIPE_DEPTH + 2 processing cycles after the cycle of the last candidate, once per completed scan.
- R5: One cycle after a returned result whose digest bits 255 down to 224 are zero, found_pulse is high for one cycle and found_nonce and found_digest hold that result's nonce and digest; no other cycle raises found_pulse.
- R6: When the first nonce is greater than the last nonce, no candidate is issued and end_pulse is raised in the cycle after the start is accepted.
- R7: A write to address 13 starts a scan only when data bits 15 down to 0 equal 0x0001; any other value there, including the no-op 0x0000, has no effect.
- R8: A start accepted during a running scan abandons the old window without an end pulse and sweeps the new window from its first nonce in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_reg | input | 1 | Host register clock (half the processing rate) |
| clk_proc | input | 1 | Processing clock |
| rst | input | 1 | Asynchronous reset, active high, both domains |
| wr_valid | input | 1 | Single-cycle host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 32 | Host write data |
| job_state | output | 256 | Captured hash-state words for the pipeline |
| job_tail | output | 96 | Captured trailing message words for the pipeline |
| cand_valid | output | 1 | Candidate nonce valid this cycle |
| cand_nonce | output | 32 | Candidate nonce |
| res_valid | input | 1 | Pipeline result valid |
| res_nonce | input | 32 | Nonce that travelled with the result |
| res_digest | input | 256 | Result digest, most significant word in bits 255:224 |
| found_pulse | output | 1 | One-cycle pulse for a qualifying digest |
| end_pulse | output | 1 | One-cycle pulse when the window is exhausted |
| found_nonce | output | 32 | Latched nonce of the last qualifying result |
| found_digest | output | 256 | Latched digest of the last qualifying result |

## Verification
The assertions watch, on every processing cycle, the stepping of candidates inside the window, the single-cycle shape of both pulses, the found decision against each returned digest, the empty-window shortcut and the first candidate after a start; in the register domain they confirm that a command other than start leaves the crossing toggle alone. What only the bench scenarios can show is the whole-scan picture: the candidate count for several windows including the top of the nonce range, the exact drain distance to the end pulse, the number of found results against an arithmetic model, that abandoned windows end with no pulse, and that job words and ignored addresses reach or miss the pipeline outputs.

// File: rtl/hjs_pkg.sv
package hjs_pkg;

    localparam int WORD_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int STATE_WORDS = 8;
    localparam int TAIL_WORDS  = 3;
    localparam int CMD_W       = 16;

    localparam logic [ADDR_W-1:0] A_TAIL_BASE = 4'd8;
    localparam logic [ADDR_W-1:0] A_FIRST     = 4'd11;
    localparam logic [ADDR_W-1:0] A_LAST      = 4'd12;
    localparam logic [ADDR_W-1:0] A_CMD       = 4'd13;

    localparam logic [CMD_W-1:0] CMD_GO = 16'h0001;

    typedef logic [STATE_WORDS-1:0][WORD_W-1:0] state_vec_t;
    typedef logic [TAIL_WORDS-1:0][WORD_W-1:0]  tail_vec_t;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_RUN   = 2'd1,
        SW_DRAIN = 2'd2
    } sweep_st_e;

endpackage

// File: rtl/hjs_host_regs.sv
module hjs_host_regs
    import hjs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output state_vec_t        state_o,
    output tail_vec_t         tail_o,
    output logic [WORD_W-1:0] first_o,
    output logic [WORD_W-1:0] last_o,
    output logic              go_tgl_o
);

    typedef struct packed {
        state_vec_t        st;
        tail_vec_t         tail;
        logic [WORD_W-1:0] first;
        logic [WORD_W-1:0] last;
        logic              tgl;
    } host_t;

    host_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_valid) begin
            if (wr_addr < A_TAIL_BASE) begin
                r_d.st[wr_addr[2:0]] = wr_data;
            end else if (wr_addr < A_FIRST) begin
                // 8, 9, 10 map to tail words 0, 1, 2 through the low bits
                r_d.tail[wr_addr[1:0]] = wr_data;
            end else if (wr_addr == A_FIRST) begin
                r_d.first = wr_data;
            end else if (wr_addr == A_LAST) begin
                r_d.last = wr_data;
            end else if (wr_addr == A_CMD) begin
                if (wr_data[CMD_W-1:0] == CMD_GO) begin
                    r_d.tgl = ~r_q.tgl;
                end
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o  = r_q.st;
    assign tail_o   = r_q.tail;
    assign first_o  = r_q.first;
    assign last_o   = r_q.last;
    assign go_tgl_o = r_q.tgl;

endmodule

// File: rtl/hjs_toggle_sync.sv
module hjs_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_in,
    output logic pulse_o
);

    localparam int CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = tgl_in;
        for (int i = 1; i < CHAIN; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    // last synchronized stage against its own delayed copy
    assign pulse_o = chain_q[STAGES-1] ^ chain_q[CHAIN-1];

endmodule

// File: rtl/hjs_sweeper.sv
module hjs_sweeper
    import hjs_pkg::*;
#(
    parameter int PIPE_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [WORD_W-1:0] first_i,
    input  logic [WORD_W-1:0] last_i,
    output logic              cand_valid_o,
    output logic [WORD_W-1:0] cand_nonce_o,
    output logic [WORD_W-1:0] last_o,
    output logic              end_pulse_o
);

    localparam int CNT_W = $clog2(PIPE_DEPTH + 1);

    typedef struct packed {
        sweep_st_e         st;
        logic [WORD_W-1:0] cur;
        logic [WORD_W-1:0] last;
        logic [CNT_W-1:0]  cnt;
        logic              end_p;
    } sweep_t;

    sweep_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.end_p = 1'b0;
        if (go) begin
            s_d.cur  = first_i;
            s_d.last = last_i;
            s_d.cnt  = '0;
            if (first_i > last_i) begin
                s_d.st    = SW_IDLE;
                s_d.end_p = 1'b1;
            end else begin
                s_d.st = SW_RUN;
            end
        end else begin
            unique case (s_q.st)
                SW_RUN: begin
                    if (s_q.cur == s_q.last) begin
                        s_d.st  = SW_DRAIN;
                        s_d.cnt = CNT_W'(PIPE_DEPTH);
                    end else begin
                        s_d.cur = s_q.cur + 1'b1;
                    end
                end
                SW_DRAIN: begin
                    if (s_q.cnt == '0) begin
                        s_d.st    = SW_IDLE;
                        s_d.end_p = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - 1'b1;
                    end
                end
                default: begin
                    s_d.st = SW_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            s_q <= '{st: SW_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cand_valid_o = (s_q.st == SW_RUN);
    assign cand_nonce_o = s_q.cur;
    assign last_o       = s_q.last;
    assign end_pulse_o  = s_q.end_p;

endmodule

// File: rtl/hjs_result_latch.sv
module hjs_result_latch
    import hjs_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          res_valid,
    input  logic [WORD_W-1:0]             res_nonce,
    input  logic [STATE_WORDS*WORD_W-1:0] res_digest,
    output logic                          found_o,
    output logic [WORD_W-1:0]             nonce_o,
    output logic [STATE_WORDS*WORD_W-1:0] digest_o
);

    localparam int DIG_W = STATE_WORDS * WORD_W;

    typedef struct packed {
        logic              hit;
        logic [WORD_W-1:0] nonce;
        logic [DIG_W-1:0]  digest;
    } latch_t;

    latch_t l_d, l_q;
    logic   top_zero;

    assign top_zero = (res_digest[DIG_W-1 -: WORD_W] == '0);

    always_comb begin
        l_d = l_q;
        l_d.hit = 1'b0;
        if (res_valid && top_zero) begin
            l_d.hit    = 1'b1;
            l_d.nonce  = res_nonce;
            l_d.digest = res_digest;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign found_o  = l_q.hit;
    assign nonce_o  = l_q.nonce;
    assign digest_o = l_q.digest;

endmodule

// File: rtl/hash_job_scanner.sv
module hash_job_scanner
    import hjs_pkg::*;
#(
    parameter int PIPE_DEPTH  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk_reg,
    input  logic                          clk_proc,
    input  logic                          rst,
    input  logic                          wr_valid,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [STATE_WORDS*WORD_W-1:0] job_state,
    output logic [TAIL_WORDS*WORD_W-1:0]  job_tail,
    output logic                          cand_valid,
    output logic [WORD_W-1:0]             cand_nonce,
    input  logic                          res_valid,
    input  logic [WORD_W-1:0]             res_nonce,
    input  logic [STATE_WORDS*WORD_W-1:0] res_digest,
    output logic                          found_pulse,
    output logic                          end_pulse,
    output logic [WORD_W-1:0]             found_nonce,
    output logic [STATE_WORDS*WORD_W-1:0] found_digest
);

    state_vec_t        host_state;
    tail_vec_t         host_tail;
    logic [WORD_W-1:0] host_first;
    logic [WORD_W-1:0] host_last;
    logic              go_toggle;
    logic              go_evt;
    logic [WORD_W-1:0] sweep_last;

    hjs_host_regs u_regs (
        .clk      (clk_reg),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .state_o  (host_state),
        .tail_o   (host_tail),
        .first_o  (host_first),
        .last_o   (host_last),
        .go_tgl_o (go_toggle)
    );

    hjs_toggle_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_proc),
        .rst     (rst),
        .tgl_in  (go_toggle),
        .pulse_o (go_evt)
    );

    // job words are sampled in the fast domain only on the synced event
    typedef struct packed {
        state_vec_t st;
        tail_vec_t  tail;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (go_evt) begin
            cap_d.st   = host_state;
            cap_d.tail = host_tail;
        end
    end

    always_ff @(posedge clk_proc or posedge rst) begin
        if (rst) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign job_state = cap_q.st;
    assign job_tail  = cap_q.tail;

    hjs_sweeper #(.PIPE_DEPTH(PIPE_DEPTH)) u_sweep (
        .clk          (clk_proc),
        .rst          (rst),
        .go           (go_evt),
        .first_i      (host_first),
        .last_i       (host_last),
        .cand_valid_o (cand_valid),
        .cand_nonce_o (cand_nonce),
        .last_o       (sweep_last),
        .end_pulse_o  (end_pulse)
    );

    hjs_result_latch u_found (
        .clk        (clk_proc),
        .rst        (rst),
        .res_valid  (res_valid),
        .res_nonce  (res_nonce),
        .res_digest (res_digest),
        .found_o    (found_pulse),
        .nonce_o    (found_nonce),
        .digest_o   (found_digest)
    );

endmodule

// File: rtl/hjs_checker.sv
module hjs_checker
    import hjs_pkg::*;
(
    input logic                          clk_reg,
    input logic                          clk_proc,
    input logic                          rst,
    input logic                          wr_valid,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [WORD_W-1:0]             wr_data,
    input logic                          go_toggle,
    input logic                          go_evt,
    input logic [WORD_W-1:0]             host_first,
    input logic [WORD_W-1:0]             host_last,
    input logic                          cand_valid,
    input logic [WORD_W-1:0]             cand_nonce,
    input logic [WORD_W-1:0]             sweep_last,
    input logic                          res_valid,
    input logic [WORD_W-1:0]             res_nonce,
    input logic [STATE_WORDS*WORD_W-1:0] res_digest,
    input logic                          found_pulse,
    input logic [WORD_W-1:0]             found_nonce,
    input logic                          end_pulse
);

    localparam int DIG_W = STATE_WORDS * WORD_W;

    logic res_hit;
    assign res_hit = res_valid && (res_digest[DIG_W-1 -: WORD_W] == '0);

    // R7
    noop_keeps_toggle_chk: assert property (@(posedge clk_reg) disable iff (rst)
        (wr_valid && wr_addr == A_CMD && wr_data[CMD_W-1:0] != CMD_GO) |=> $stable(go_toggle));

    // R3
    cand_step_chk: assert property (@(posedge clk_proc) disable iff (rst)
        (cand_valid && !go_evt && cand_nonce != sweep_last)
            |=> (cand_valid && cand_nonce == $past(cand_nonce) + 1'b1));

    // R3
    cand_in_window_chk: assert property (@(posedge clk_proc) disable iff (rst)
        cand_valid |-> (cand_nonce <= sweep_last));

    // R4
    end_single_chk: assert property (@(posedge clk_proc) disable iff (rst)
        end_pulse |=> !end_pulse);

    // R5
    found_on_hit_chk: assert property (@(posedge clk_proc) disable iff (rst)
        res_hit |=> (found_pulse && found_nonce == $past(res_nonce)));

    // R5
    found_only_hit_chk: assert property (@(posedge clk_proc) disable iff (rst)
        !res_hit |=> !found_pulse);

    // R6
    empty_window_chk: assert property (@(posedge clk_proc) disable iff (rst)
        (go_evt && host_first > host_last) |=> (end_pulse && !cand_valid));

    // R8
    restart_first_chk: assert property (@(posedge clk_proc) disable iff (rst)
        (go_evt && host_first <= host_last) |=> (cand_valid && cand_nonce == $past(host_first)));

endmodule

bind hash_job_scanner hjs_checker u_chk (
    .clk_reg     (clk_reg),
    .clk_proc    (clk_proc),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .go_toggle   (go_toggle),
    .go_evt      (go_evt),
    .host_first  (host_first),
    .host_last   (host_last),
    .cand_valid  (cand_valid),
    .cand_nonce  (cand_nonce),
    .sweep_last  (sweep_last),
    .res_valid   (res_valid),
    .res_nonce   (res_nonce),
    .res_digest  (res_digest),
    .found_pulse (found_pulse),
    .found_nonce (found_nonce),
    .end_pulse   (end_pulse)
);

// File: tb/tb_hash_job_scanner.sv
`timescale 1ns/1ps
module tb_hash_job_scanner;

    localparam int PD = 6;

    logic         clk_reg = 1'b0;
    logic         clk_proc = 1'b0;
    logic         rst = 1'b1;
    logic         wr_valid = 1'b0;
    logic [3:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [255:0] job_state;
    logic [95:0]  job_tail;
    logic         cand_valid;
    logic [31:0]  cand_nonce;
    logic         res_valid;
    logic [31:0]  res_nonce;
    logic [255:0] res_digest;
    logic         found_pulse;
    logic         end_pulse;
    logic [31:0]  found_nonce;
    logic [255:0] found_digest;

    always #10 clk_proc = ~clk_proc;  // 50 MHz processing clock
    always #20 clk_reg  = ~clk_reg;   // register clock at half rate

    hash_job_scanner #(.PIPE_DEPTH(PD), .SYNC_STAGES(2)) dut (
        .clk_reg(clk_reg), .clk_proc(clk_proc), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .job_state(job_state), .job_tail(job_tail),
        .cand_valid(cand_valid), .cand_nonce(cand_nonce),
        .res_valid(res_valid), .res_nonce(res_nonce), .res_digest(res_digest),
        .found_pulse(found_pulse), .end_pulse(end_pulse),
        .found_nonce(found_nonce), .found_digest(found_digest)
    );

    // arithmetic digest model: top word zero exactly for multiples of 5
    function automatic logic [255:0] dig(input logic [31:0] n);
        logic [255:0] r;
        for (int j = 0; j < 7; j++) r[32*j +: 32] = n ^ (32'h0101_0101 * j);
        r[255:224] = (n % 5 == 0) ? 32'h0 : (n | 32'h1);
        return r;
    endfunction

    // hash pipeline model of fixed depth PD
    logic        pv [PD];
    logic [31:0] pn [PD];
    always @(posedge clk_proc or posedge rst) begin
        if (rst) begin
            for (int i = 0; i < PD; i++) begin pv[i] <= 1'b0; pn[i] <= '0; end
        end else begin
            pv[0] <= cand_valid; pn[0] <= cand_nonce;
            for (int i = 1; i < PD; i++) begin pv[i] <= pv[i-1]; pn[i] <= pn[i-1]; end
        end
    end
    assign res_valid  = pv[PD-1];
    assign res_nonce  = pn[PD-1];
    assign res_digest = dig(pn[PD-1]);

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor statistics
    int          cyc = 0, ncand = 0, jumps = 0, nend = 0, nfound = 0, hi_cnt = 0;
    int          last_cyc = 0, end_cyc = 0;
    logic [31:0] firstn = '0, lastn = '0;
    bit          pend = 1'b0;
    logic [31:0] pend_n = '0;

    always @(negedge clk_proc) begin
        if (!rst) begin
            cyc++;
            if (cand_valid) begin
                if (ncand == 0) firstn = cand_nonce;
                else if (cand_nonce != lastn + 32'd1) jumps++;
                lastn = cand_nonce;
                ncand++;
                last_cyc = cyc;
                if (cand_nonce >= 32'h5000 && cand_nonce <= 32'h50FF) hi_cnt++;
            end
            if (end_pulse) begin nend++; end_cyc = cyc; end
            if (pend || found_pulse) begin
                // R5 found pulse, nonce and digest one cycle after a zero-top result
                chk(pend == found_pulse, "R5 pulse", found_pulse, pend);
                if (pend) begin
                    chk(found_nonce == pend_n, "R5 nonce", found_nonce, pend_n);
                    chk(found_digest == dig(pend_n), "R5 digest", found_digest[31:0], dig(pend_n)[31:0]);
                end
            end
            if (found_pulse) nfound++;
            pend   = res_valid && (res_digest[255:224] == 32'h0);
            pend_n = res_nonce;
        end
    end

    task automatic clear_stats();
        @(posedge clk_proc);
        ncand = 0; jumps = 0; nend = 0; nfound = 0; hi_cnt = 0;
    endtask

    task automatic host_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk_reg);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk_reg);
        wr_valid = 1'b0;
    endtask

    task automatic wait_end();
        int k = 0;
        while (nend == 0 && k < 2000) begin @(negedge clk_proc); k++; end
        repeat (PD + 4) @(negedge clk_proc);
    endtask

    function automatic int mult5(input longint s, input longint e);
        int c = 0;
        for (longint n = s; n <= e; n++) if (n % 5 == 0) c++;
        return c;
    endfunction

    task automatic run_scan(input logic [31:0] s, input logic [31:0] e);
        clear_stats();
        host_wr(4'd11, s);
        host_wr(4'd12, e);
        host_wr(4'd13, 32'h0000_0001);
        wait_end();
        // R3 count, first, last and step of the candidates
        chk(ncand == int'(longint'(e) - longint'(s) + 1), "R3 count", ncand, longint'(e) - longint'(s) + 1);
        chk(firstn == s, "R3 first", firstn, s);
        chk(lastn == e, "R3 last", lastn, e);
        chk(jumps == 0, "R3 step", jumps, 0);
        // R4 one end pulse at the drain distance
        chk(nend == 1, "R4 count", nend, 1);
        chk(end_cyc - last_cyc == PD + 2, "R4 delay", end_cyc - last_cyc, PD + 2);
        // R5 number of found results
        chk(nfound == mult5(s, e), "R5 found count", nfound, mult5(s, e));
    endtask

    task automatic check_job();
        // R2 job words presented after the start
        for (int i = 0; i < 8; i++)
            chk(job_state[32*i +: 32] == 32'hC0DE_0000 + 32'h11 * i, "R2 state", job_state[32*i +: 32], 32'hC0DE_0000 + 32'h11 * i);
        for (int i = 0; i < 3; i++)
            chk(job_tail[32*i +: 32] == 32'h7A11_0000 + i, "R2 tail", job_tail[32*i +: 32], 32'h7A11_0000 + i);
    endtask

    initial begin
        repeat (3) @(negedge clk_proc);
        // R1 reset state
        chk(cand_valid == 1'b0, "R1 cand_valid", cand_valid, 0);
        chk(found_pulse == 1'b0, "R1 found_pulse", found_pulse, 0);
        chk(end_pulse == 1'b0, "R1 end_pulse", end_pulse, 0);
        chk(found_nonce == '0, "R1 found_nonce", found_nonce, 0);
        chk(found_digest == '0, "R1 found_digest", found_digest[31:0], 0);
        chk(job_state == '0 && job_tail == '0, "R1 job", job_state[31:0], 0);
        @(negedge clk_reg);
        rst = 1'b0;

        for (int i = 0; i < 8; i++) host_wr(4'(i), 32'hC0DE_0000 + 32'h11 * i);
        for (int i = 0; i < 3; i++) host_wr(4'(8 + i), 32'h7A11_0000 + i);

        run_scan(32'h100, 32'h1FF);
        check_job();
        run_scan(32'h7, 32'h7);
        run_scan(32'h0, 32'h4);
        run_scan(32'hFFFF_FFF0, 32'hFFFF_FFFF);   // R3 top of the nonce range

        // R6 empty window
        clear_stats();
        host_wr(4'd11, 32'h20);
        host_wr(4'd12, 32'h10);
        host_wr(4'd13, 32'h1);
        wait_end();
        chk(ncand == 0, "R6 no candidates", ncand, 0);
        chk(nend == 1, "R6 end pulse", nend, 1);

        // R7 no-op and other command values; R2 unused addresses
        clear_stats();
        host_wr(4'd11, 32'h40);
        host_wr(4'd12, 32'h44);
        host_wr(4'd13, 32'h0000_0000);
        host_wr(4'd13, 32'h0000_0002);
        host_wr(4'd14, 32'hDEAD_BEEF);
        host_wr(4'd15, 32'hDEAD_BEEF);
        repeat (60) @(negedge clk_proc);
        chk(ncand == 0, "R7 no candidates", ncand, 0);
        chk(nend == 0, "R7 no end", nend, 0);
        run_scan(32'h40, 32'h44);
        check_job();

        // R8 restart during a running scan
        clear_stats();
        host_wr(4'd11, 32'h100);
        host_wr(4'd12, 32'h1FF);
        host_wr(4'd13, 32'h1);
        while (ncand < 20) @(negedge clk_proc);
        host_wr(4'd11, 32'h5000);
        host_wr(4'd12, 32'h5009);
        host_wr(4'd13, 32'h1);
        wait_end();
        chk(nend == 1, "R8 single end", nend, 1);
        chk(lastn == 32'h5009, "R8 last", lastn, 32'h5009);
        chk(hi_cnt == 10, "R8 new window count", hi_cnt, 10);
        chk(jumps == 1, "R8 one jump", jumps, 1);
        chk(ncand < 10 + 256, "R8 old window cut", ncand, 266);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_proc);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule